// File: doc/BRIEF.md
# Table-Driven State Machine with Compressed Lookup Address

This block is a synchronous state machine whose whole transition and output behaviour lives in a constant lookup table. There is no hand-written next-state logic. The present state and the primary inputs form a vector. Part of that vector goes straight to the table's address lines. Another part is first folded by a small combinational compressor, itself a constant truth table, into fewer bits. The table therefore needs only 2^(a+c) words instead of the 2^(m+n) words a direct lookup would need. Each word carries the encoded next state in its upper bits and the output values in its lower bits. The next state is written back as the present state.

Two storage variants are selected by a parameter. In the first, a plain state register holds the present state, the table is read combinationally, and the outputs are a Mealy function of the present state and the current inputs. In the second, the table read itself is clocked, as a synchronous-read memory would be. The captured word then acts as the state register, and the outputs appear one cycle later, registered. Both variants have a synchronous active-high reset to a parameterised start state and a clock enable.

The default configuration has two inputs (x1 is bit 1 and x2 is bit 0 of `x_i`) and three state bits (q1 is bit 2, q2 is bit 1 and q3 is bit 0 of the state). The bits x1, x2 and q1 pass straight through to the address. The compressor reads x1, q2 and q3 and produces one bit g. The result is a 4-bit, 16-word table in place of a 5-bit, 32-word one.

Top module: `romfsm_core`

## Requirements
- R1: In the default (combinational-read) variant, a clock edge with `rst` high loads state 3'b101. While `rst` is high, `state_o` reads 3'b101 and `y_o` equals the output rule of R4 applied to state 3'b101 and the current `x_i`. Reset takes precedence over `en`.
- R2: The compressor bit is g = x1 ^ q2 ^ q3. The table address is {q1, x1, x2, g}, which is 4 bits and 16 words, so it is narrower than the 5-bit direct address. For every one of the 32 state and input pairs, the design matches the direct rules of R3 and R4. A configuration whose address would not be narrower than state plus input bits is rejected at elaboration.
- R3: On a clock edge with `en` high and `rst` low, the state becomes {q1 ^ x1, g ^ x2, g ^ x1}.
- R4: In the default variant, `y_o` = {q1 & g, x1 ^ x2 ^ g}, computed combinationally from the present state and the current `x_i`.
- R5: On an edge with `en` low and `rst` low, the state is unchanged. In the default variant, `y_o` keeps following `x_i` against the held state.
- R6: In the registered-read variant, `y_o` equals the R4 rule evaluated on the state and input present at the most recent enabled edge. It holds its value across edges with `en` low.
- R7: In the registered-read variant, `y_o` reads 0 while `rst` is high and after reset until the first enabled edge. `state_o` reads 3'b101 over the same span.
- R8: Under identical stimulus, the registered-read variant goes through the same state sequence as the default variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to the start state |
| en | input | 1 | Clock enable for the state update |
| x_i | input | N_IN | Primary inputs (x1 is the MSB) |
| state_o | output | N_ST | Present state (q1 is the MSB) |
| y_o | output | N_OUT | Machine outputs |

## Verification
The hard part is reaching every state together with every input. The low state bit is set by the previous state only (q3 becomes q2 ^ q3), so no single input choice can steer to an arbitrary state. The bench uses its own model to compute a two-step input sequence that lands on each of the eight states. At each state it holds `en` low and sweeps all four input values, which covers all 32 address pairs and tests the hold behaviour at the same time. A pseudo-random run with resets in the middle of operation and gaps in `en` then compares both variants against the direct rules.

// File: rtl/romfsm_pkg.sv
package romfsm_pkg;

   // Default compressor truth table: entry i holds g for the index
   // {q2, q3, x1}, and g is the parity of those three bits.
   function automatic logic [7:0] ref_mod_table();
      logic [7:0] t;
      for (int i = 0; i < 8; i++) begin
         t[i] = ^(3'(i));
      end
      return t;
   endfunction

   // Default lookup table: the address is {q1, x1, x2, g}, and each word
   // is {next state (3 bits), outputs (2 bits)}.
   function automatic logic [79:0] ref_rom_table();
      logic [79:0] t;
      logic [3:0]  a;
      logic [2:0]  ns;
      logic [1:0]  yv;
      for (int i = 0; i < 16; i++) begin
         a  = 4'(i);
         ns = {a[3] ^ a[2], a[0] ^ a[1], a[0] ^ a[2]};
         yv = {a[3] & a[0], a[2] ^ a[1] ^ a[0]};
         t[i*5 +: 5] = {ns, yv};
      end
      return t;
   endfunction

endpackage

// File: rtl/romfsm_addr_mod.sv
module romfsm_addr_mod #(
   parameter int L         = 5,
   parameter logic [L-1:0] FREE_MASK = 5'b10011,
   parameter logic [L-1:0] MOD_MASK  = 5'b01110,
   parameter int A         = 3,
   parameter int B         = 3,
   parameter int C         = 1,
   parameter logic [(2**B)*C-1:0] MOD_TABLE = romfsm_pkg::ref_mod_table()
) (
   input  logic [L-1:0]   vec_i,
   output logic [A+C-1:0] addr_o
);

   // Position of the k-th set bit of a selection mask.
   function automatic int bit_pos(logic [L-1:0] mask, int k);
      int cnt;
      int pos;
      cnt = 0;
      pos = 0;
      for (int i = 0; i < L; i++) begin
         if (mask[i]) begin
            if (cnt == k) pos = i;
            cnt++;
         end
      end
      return pos;
   endfunction

   logic [A-1:0] free_w;
   logic [B-1:0] mod_w;
   logic [C-1:0] g_w;

   for (genvar k = 0; k < A; k++) begin : g_free
      assign free_w[k] = vec_i[bit_pos(FREE_MASK, k)];
   end

   for (genvar k = 0; k < B; k++) begin : g_mod
      assign mod_w[k] = vec_i[bit_pos(MOD_MASK, k)];
   end

   assign g_w    = MOD_TABLE[int'(mod_w)*C +: C];
   assign addr_o = {free_w, g_w};

   initial begin
      assert_free_count_R2: assert ($countones(FREE_MASK) == A)
         else $error("free mask does not select A bits");
      assert_mod_count_R2: assert ($countones(MOD_MASK) == B)
         else $error("modifier mask does not select B bits");
      assert_mod_shrinks_R2: assert (C < B)
         else $error("modifier must have fewer outputs than inputs");
   end

endmodule

// File: rtl/romfsm_rom.sv
module romfsm_rom #(
   parameter int W    = 4,
   parameter int WORD = 5,
   parameter logic [(2**W)*WORD-1:0] ROM_TABLE = romfsm_pkg::ref_rom_table()
) (
   input  logic [W-1:0]    addr_i,
   output logic [WORD-1:0] word_o
);

   localparam int DEPTH = 2**W;

   // Constant table, addressed as an array of words.
   logic [WORD-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      assign tbl[i] = ROM_TABLE[i*WORD +: WORD];
   end

   assign word_o = tbl[addr_i];

endmodule

// File: rtl/romfsm_core.sv
module romfsm_core #(
   parameter int N_IN      = 2,
   parameter int N_ST      = 3,
   parameter int N_OUT     = 2,
   parameter logic [N_ST+N_IN-1:0] FREE_MASK = 5'b10011,
   parameter logic [N_ST+N_IN-1:0] MOD_MASK  = 5'b01110,
   parameter int FREE_BITS = 3,
   parameter int MOD_BITS  = 3,
   parameter int MOD_OUT   = 1,
   parameter logic [N_ST-1:0] INIT_STATE = 3'b101,
   parameter bit REG_READ  = 1'b0,
   parameter logic [(2**MOD_BITS)*MOD_OUT-1:0] MOD_TABLE = romfsm_pkg::ref_mod_table(),
   parameter logic [(2**(FREE_BITS+MOD_OUT))*(N_ST+N_OUT)-1:0] ROM_TABLE =
      romfsm_pkg::ref_rom_table()
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [N_IN-1:0]  x_i,
   output logic [N_ST-1:0]  state_o,
   output logic [N_OUT-1:0] y_o
);

   localparam int L             = N_ST + N_IN;
   localparam int W             = FREE_BITS + MOD_OUT;
   localparam int WORD          = N_ST + N_OUT;
   localparam int DIRECT_WORDS  = 2**L;
   localparam int REDUCED_WORDS = 2**W;
   localparam int DIRECT_BITS   = DIRECT_WORDS * WORD;
   localparam int REDUCED_BITS  = REDUCED_WORDS * WORD;

   logic [N_ST-1:0]  pres_st;
   logic [L-1:0]     vec_w;
   logic [W-1:0]     addr_w;
   logic [WORD-1:0]  word_w;
   logic [N_ST-1:0]  ns_w;
   logic [N_OUT-1:0] y_w;

   assign vec_w = {pres_st, x_i};

   romfsm_addr_mod #(
      .L(L), .FREE_MASK(FREE_MASK), .MOD_MASK(MOD_MASK),
      .A(FREE_BITS), .B(MOD_BITS), .C(MOD_OUT), .MOD_TABLE(MOD_TABLE)
   ) u_amod (
      .vec_i (vec_w),
      .addr_o(addr_w)
   );

   romfsm_rom #(
      .W(W), .WORD(WORD), .ROM_TABLE(ROM_TABLE)
   ) u_rom (
      .addr_i(addr_w),
      .word_o(word_w)
   );

   assign ns_w    = word_w[WORD-1 -: N_ST];
   assign y_w     = word_w[N_OUT-1:0];
   assign state_o = pres_st;

   if (REG_READ == 1'b0) begin : g_statereg
      logic [N_ST-1:0] state_q;

      always_ff @(posedge clk) begin
         if (rst)     state_q <= INIT_STATE;
         else if (en) state_q <= ns_w;
      end

      assign pres_st = rst ? INIT_STATE : state_q;
      assign y_o     = y_w;
   end else begin : g_syncread
      logic [WORD-1:0] word_q;

      always_ff @(posedge clk) begin
         if (rst)     word_q <= {INIT_STATE, {N_OUT{1'b0}}};
         else if (en) word_q <= word_w;
      end

      assign pres_st = rst ? INIT_STATE : word_q[WORD-1 -: N_ST];
      assign y_o     = rst ? '0 : word_q[N_OUT-1:0];

      assert_rr_reset_out_R7: assert property (@(posedge clk)
         rst |=> (y_o == '0));
      assert_rr_out_R6: assert property (@(posedge clk) disable iff (rst)
         en |=> (y_o == $past(y_w)));
      assert_rr_hold_R6: assert property (@(posedge clk) disable iff (rst)
         !en |=> $stable(y_o));
   end

   initial begin
      assert_narrow_addr_R2: assert (W < L)
         else $error("reduced address is not narrower than the direct one");
      assert_smaller_table_R2: assert (REDUCED_BITS < DIRECT_BITS)
         else $error("reduced table is not smaller");
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (state_o == INIT_STATE));
   assert_next_state_R3: assert property (@(posedge clk) disable iff (rst)
      en |=> (state_o == $past(ns_w)));
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(state_o));

endmodule

// File: tb/romfsm_core_tb.sv
`timescale 1ns/1ps
module romfsm_core_tb;

   localparam logic [2:0] INIT = 3'b101;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [1:0] x   = 2'b00;
   logic [2:0] st0, st1;
   logic [1:0] y0, y1;

   always #2 clk = ~clk;

   romfsm_core #(.REG_READ(1'b0)) u_dut (
      .clk(clk), .rst(rst), .en(en), .x_i(x), .state_o(st0), .y_o(y0));

   romfsm_core #(.REG_READ(1'b1)) u_dut_rr (
      .clk(clk), .rst(rst), .en(en), .x_i(x), .state_o(st1), .y_o(y1));

   int          total = 0;
   int          bad   = 0;
   bit          done  = 0;
   logic [2:0]  mq    = INIT;
   logic [1:0]  ry    = 2'b00;
   bit          fresh = 1;
   bit          en_prev = 1;
   logic [31:0] cov   = '0;

   function automatic logic [2:0] f_ns(logic [2:0] q, logic [1:0] xv);
      logic g;
      g = xv[1] ^ q[1] ^ q[0];
      return {q[2] ^ xv[1], g ^ xv[0], g ^ xv[1]};
   endfunction

   function automatic logic [1:0] f_y(logic [2:0] q, logic [1:0] xv);
      logic g;
      g = xv[1] ^ q[1] ^ q[0];
      return {q[2] & g, xv[1] ^ xv[0] ^ g};
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One cycle: drive, check after settling, then advance the model at the edge.
   task automatic step(input logic r, input logic e, input logic [1:0] xv);
      logic [2:0] es;
      rst = r; en = e; x = xv;
      #1;
      es = r ? INIT : mq;
      chk(r ? "R1" : (en_prev ? "R3" : "R5"), "state comb-read", int'(st0), int'(es));
      chk(r ? "R1" : (e ? "R4" : "R5"), "out comb-read", int'(y0), int'(f_y(es, xv)));
      chk("R8", "state sync-read", int'(st1), int'(es));
      chk((r || fresh) ? "R7" : "R6", "out sync-read", int'(y1), r ? 0 : int'(ry));
      if (!r) cov[{mq, xv}] = 1'b1;
      @(posedge clk);
      if (r) begin
         mq = INIT; ry = 2'b00; fresh = 1; en_prev = 1;
      end else if (e) begin
         ry = f_y(mq, xv); mq = f_ns(mq, xv); fresh = 0; en_prev = 1;
      end else begin
         en_prev = 0;
      end
      @(negedge clk);
   endtask

   // Two enabled steps that land on state t from any state.
   task automatic goto(input logic [2:0] t);
      logic x1a, x2a, x1b, x2b, g;
      x1a = 1'b0;
      g   = x1a ^ mq[1] ^ mq[0];
      x2a = g ^ t[0] ^ mq[1] ^ mq[0];
      step(1'b0, 1'b1, {x1a, x2a});
      x1b = mq[2] ^ t[2];
      g   = x1b ^ mq[1] ^ mq[0];
      x2b = g ^ t[1];
      step(1'b0, 1'b1, {x1b, x2b});
      chk("R3", "steered state", int'(st0), int'(t));
   endtask

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      step(1'b1, 1'b0, 2'b00);            // R1 reset from time zero
      step(1'b1, 1'b1, 2'b11);            // R1 reset beats enable
      step(1'b0, 1'b0, 2'b10);            // R7 output still zero
      for (int t = 0; t < 8; t++) begin
         goto(3'(t));
         for (int xv = 0; xv < 4; xv++) step(1'b0, 1'b0, 2'(xv));  // R5, R4
         step(1'b0, 1'b1, 2'(t));
         step(1'b0, 1'b0, 2'(3 - (t % 4)));                       // R6 hold
      end
      step(1'b1, 1'b1, 2'b10);            // mid-run reset
      step(1'b0, 1'b0, 2'b01);            // R7
      step(1'b0, 1'b0, 2'b11);            // R7
      for (int i = 0; i < 600; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[9:5] == 5'd0, lf[3:2] != 2'b00, lf[1:0]);
      end
      chk("R2", "all 32 pairs visited", int'(cov == 32'hFFFF_FFFF), 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule